// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic core of a small 8-bit controller. An operation decoder turns a 5-bit instruction field and a 2-bit mode input into an internal operation. A purely combinational datapath applies that operation to two byte operands. It produces a byte result together with carry, nibble (auxiliary) carry and zero. A three-bit status register captures those flags on a clock edge, but only when the flag-write strobe is high.

The mode input lets the sequencer that drives the block reuse it for work that has nothing to do with the instruction. One mode value forces a plain add, for example to step a program counter. Another mode value routes operand A straight through. Only the remaining mode values let the instruction field pick the operation.

All pins are plain control and data pins. No data is queued, so there is no valid/ready handshake and no back-pressure. The result follows the inputs within the same cycle, and the flags change only at a rising clock edge.

Top module: `byte_alu_core`

## Requirements
- R1: When mode is 2'b10, result equals (A + B) mod 256 whatever the instruction field holds.
- R2: When mode is 2'b00, result equals A.
- R3: When mode is 2'b01 or 2'b11, field code 0 gives A + B and field code 1 gives A - B, both mod 256.
- R4: In decode modes, field code 2 gives A AND B, code 3 gives A OR B, and code 4 gives A XOR B.
- R5: In decode modes, field code 5 gives A + 1 and field code 6 gives A - 1, both mod 256. Field code 7 gives B.
- R6: In decode modes, field codes 8 through 31 give A unchanged.
- R7: An add that is captured sets carry to the carry out of bit 7 and sets the nibble carry to the carry from bit 3 into bit 4.
- R8: A subtract that is captured is computed as A + ~B + 1. Carry is set to 1 when there is no borrow (A >= B). The nibble carry is set to 1 when A[3:0] >= B[3:0].
- R9: Every capture sets zero to 1 exactly when the 8-bit result is 0.
- R10: A capture of any operation other than add or subtract leaves carry and nibble carry unchanged.
- R11: While the flag-write strobe is low, all three flags hold their values.
- R12: An active-low reset clears all three flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| insn_fld | input | 5 | Operation field from the instruction |
| alu_mode | input | 2 | 00 pass A, 10 force add, 01/11 decode the field |
| flag_we | input | 1 | Capture the flags at this clock edge |
| result | output | 8 | Combinational result |
| flag_c | output | 1 | Registered carry (no-borrow for subtract) |
| flag_dc | output | 1 | Registered nibble carry |
| flag_z | output | 1 | Registered zero |

## Verification
The assertions assume that every input holds a known, settled value at each rising edge. They also assume that reset is released only between edges, so that each past-value comparison refers to a cycle that came after reset. The bench changes the inputs only on the falling edge and keeps reset low across several edges before it releases it. It draws random operands, fields, modes and write strobes, and adds directed cases for carries across the nibble boundary, wraparound and results of zero.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_PASS_A = 4'd0,
    OP_ADD    = 4'd1,
    OP_SUB    = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_XOR    = 4'd5,
    OP_INC    = 4'd6,
    OP_DEC    = 4'd7,
    OP_PASS_B = 4'd8
  } alu_op_e;

  localparam logic [1:0] MODE_PASS = 2'b00;
  localparam logic [1:0] MODE_ADD  = 2'b10;
endpackage

// File: rtl/alu8_op_decode.sv
module alu8_op_decode
  import alu8_pkg::*;
#(
  parameter int FW = 5
) (
  input  logic [FW-1:0] insn_fld,
  input  logic [1:0]    alu_mode,
  output alu_op_e       op
);
  always_comb begin
    if (alu_mode == MODE_ADD) begin
      op = OP_ADD;
    end else if (alu_mode == MODE_PASS) begin
      op = OP_PASS_A;
    end else begin
      case (insn_fld)
        FW'(0):  op = OP_ADD;
        FW'(1):  op = OP_SUB;
        FW'(2):  op = OP_AND;
        FW'(3):  op = OP_OR;
        FW'(4):  op = OP_XOR;
        FW'(5):  op = OP_INC;
        FW'(6):  op = OP_DEC;
        FW'(7):  op = OP_PASS_B;
        default: op = OP_PASS_A;
      endcase
    end
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         c_nxt,
  output logic         dc_nxt,
  output logic         z_nxt,
  output logic         arith
);
  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [NIB:0] lo_sum;

  assign is_sub = (op == OP_SUB);
  assign arith  = (op == OP_ADD) || is_sub;
  assign b_eff  = is_sub ? ~b : b;
  assign sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign lo_sum = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, is_sub};

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: y = sum[W-1:0];
      OP_AND:         y = a & b;
      OP_OR:          y = a | b;
      OP_XOR:         y = a ^ b;
      OP_INC:         y = a + W'(1);
      OP_DEC:         y = a - W'(1);
      OP_PASS_B:      y = b;
      default:        y = a;
    endcase
  end

  assign c_nxt  = sum[W];
  assign dc_nxt = lo_sum[NIB];
  assign z_nxt  = (y == '0);
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic arith,
  input  logic c_nxt,
  input  logic dc_nxt,
  input  logic z_nxt,
  output logic c_q,
  output logic dc_q,
  output logic z_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q  <= 1'b0;
      dc_q <= 1'b0;
      z_q  <= 1'b0;
    end else if (we) begin
      z_q <= z_nxt;
      if (arith) begin
        c_q  <= c_nxt;
        dc_q <= dc_nxt;
      end
    end
  end
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import alu8_pkg::*;
#(
  parameter int W   = 8,
  parameter int FW  = 5,
  parameter int NIB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [FW-1:0] insn_fld,
  input  logic [1:0]    alu_mode,
  input  logic          flag_we,
  output logic [W-1:0]  result,
  output logic          flag_c,
  output logic          flag_dc,
  output logic          flag_z
);
  alu_op_e op;
  logic    c_nxt, dc_nxt, z_nxt, arith;

  alu8_op_decode #(.FW(FW)) u_dec (
    .insn_fld (insn_fld),
    .alu_mode (alu_mode),
    .op       (op)
  );

  alu8_datapath #(.W(W), .NIB(NIB)) u_dp (
    .a      (opnd_a),
    .b      (opnd_b),
    .op     (op),
    .y      (result),
    .c_nxt  (c_nxt),
    .dc_nxt (dc_nxt),
    .z_nxt  (z_nxt),
    .arith  (arith)
  );

  alu8_status_reg u_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (flag_we),
    .arith  (arith),
    .c_nxt  (c_nxt),
    .dc_nxt (dc_nxt),
    .z_nxt  (z_nxt),
    .c_q    (flag_c),
    .dc_q   (flag_dc),
    .z_q    (flag_z)
  );
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int W  = 8,
  parameter int FW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  opnd_a,
  input logic [W-1:0]  opnd_b,
  input logic [FW-1:0] insn_fld,
  input logic [1:0]    alu_mode,
  input logic          flag_we,
  input logic [W-1:0]  result,
  input logic          flag_c,
  input logic          flag_dc,
  input logic          flag_z
);
  logic is_logic;
  assign is_logic = alu_mode[0] && (insn_fld >= FW'(2)) && (insn_fld <= FW'(4));

  // R1
  force_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_mode == 2'b10 |-> result == W'(opnd_a + opnd_b));

  // R2
  pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_mode == 2'b00 |-> result == opnd_a);

  // R7
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && alu_mode == 2'b10) |=>
      flag_c == $past(({1'b0, opnd_a} + {1'b0, opnd_b}) > {1'b0, {W{1'b1}}}));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flag_z == ($past(result) == '0));

  // R10
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_logic) |=> $stable({flag_c, flag_dc}));

  // R11
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable({flag_c, flag_dc, flag_z}));
endmodule

bind byte_alu_core alu8_chk #(.W(W), .FW(FW)) u_chk (.*);

// File: tb/sim_byte_alu_core.sv
module sim_byte_alu_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic [4:0] insn_fld = '0;
  logic [1:0] alu_mode = '0;
  logic       flag_we = 1'b0;
  logic [7:0] result;
  logic       flag_c, flag_dc, flag_z;

  int checks = 0;
  int errors = 0;
  bit m_c = 0, m_dc = 0, m_z = 0;

  always #2 clk = ~clk;

  byte_alu_core u0 (.*);

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Behavioural reference: returns result, carry, nibble carry, and whether add/sub
  task automatic model(input int a, input int b, input int fld, input int mode,
                       output int r, output int c, output int dc, output int ar,
                       output string tag);
    int code;
    code = (mode == 2) ? 0 : (mode == 0) ? 99 : fld;
    ar = 0; c = 0; dc = 0;
    tag = (mode == 2) ? "R1" : (mode == 0) ? "R2" : "R6";
    case (code)
      0: begin r = a + b; c = (a + b) > 255; dc = (a % 16 + b % 16) > 15; ar = 1;
               if (mode != 2) tag = "R3"; end
      1: begin r = a - b; c = (a >= b); dc = (a % 16 >= b % 16); ar = 2; tag = "R3"; end
      2: begin r = a & b; tag = "R4"; end
      3: begin r = a | b; tag = "R4"; end
      4: begin r = a ^ b; tag = "R4"; end
      5: begin r = a + 1; tag = "R5"; end
      6: begin r = a - 1; tag = "R5"; end
      7: begin r = b; tag = "R5"; end
      default: r = a;
    endcase
    r = r & 255;
  endtask

  task automatic step(input int a, input int b, input int fld, input int mode, input bit we);
    int r, c, dc, ar;
    string tag;
    @(negedge clk);
    opnd_a = 8'(a); opnd_b = 8'(b); insn_fld = 5'(fld); alu_mode = 2'(mode); flag_we = we;
    #1;
    model(a, b, fld, mode, r, c, dc, ar, tag);
    chk(tag, int'(result), r);
    @(posedge clk);
    if (we) begin
      m_z = (r == 0);
      if (ar != 0) begin m_c = c[0]; m_dc = dc[0]; end
    end
    #1;
    if (!we) begin
      chk("R11 flags", int'({flag_c, flag_dc, flag_z}), int'({m_c, m_dc, m_z}));
    end else begin
      chk("R9 zero", int'(flag_z), int'(m_z));
      chk(ar == 1 ? "R7 carry" : ar == 2 ? "R8 carry" : "R10 carry",
          int'({flag_c, flag_dc}), int'({m_c, m_dc}));
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk("R12 reset", int'({flag_c, flag_dc, flag_z}), 0);
    @(negedge clk) rst_n = 1'b1;
    // R7: nibble carry without carry, then full carry with zero
    step(8'h0F, 8'h01, 3, 2, 1);
    step(8'hFF, 8'h01, 0, 1, 1);
    // R10: logic op after carry set keeps carry
    step(8'hF0, 8'h0F, 2, 1, 1);
    // R8: equal subtract -> no borrow, zero; then borrow case
    step(8'h05, 8'h05, 1, 3, 1);
    step(8'h03, 8'h05, 1, 1, 1);
    step(8'h10, 8'h01, 1, 1, 1);
    // R5: increment/decrement wrap
    step(8'hFF, 8'h00, 5, 1, 1);
    step(8'h00, 8'h00, 6, 3, 1);
    // R6: undefined codes
    step(8'h5A, 8'h11, 8, 1, 1);
    step(8'h00, 8'h11, 31, 3, 1);
    // R2 pass with strobe low (R11)
    step(8'h00, 8'hAA, 1, 0, 0);
    for (int i = 0; i < 600; i++)
      step($urandom_range(255), $urandom_range(255), $urandom_range(31),
           $urandom_range(3), 1'($urandom_range(1)));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule